// File: doc/BRIEF.md
# Instruction Store Byte Loader

This block lets a host fill a 512-word, 32-bit instruction store one byte at a time. The host picks a word with two address registers. It sets the load-enable bit in a control register and then pushes four bytes into a single byte-wide data window, least significant byte first. The first three bytes are held in a staging register. The fourth byte completes the word: the whole word is written into the store and the word address steps forward by one.

The same window reads back the addressed word. Each read returns the next byte, in the same lane order as writes use, and the address advances after the fourth read. The control register also holds the sequencer's mode flags. One of its bits is a self-clearing reset that forces the sequencer program counter to zero. The block keeps that program counter and steps it when the sequencer asks; executing the instructions is left to logic outside this block.

Top module: `ucode_loader`

## Requirements
- R1: With load enable (control bit 0) set, four window writes (register select 1) form one word. The first write is bits 7:0 and the fourth is bits 31:24. The word is written to the store only when the fourth byte arrives.
- R2: The word address goes up by one after the fourth window write, and not after the first three.
- R3: The word address wraps from 511 to 0.
- R4: While load enable is clear, window writes change neither the store, the address nor the byte lane.
- R5: A write to the low address register (select 2) sets address bits 7:0. A write to the high address register (select 3) sets address bit 8 from data bit 0. Either write returns the byte lane to 0 and drops any partly assembled word.
- R6: A control write (select 0) stores all eight bits. If data bit 1 is set, the program counter is 0 after that edge, and bit 1 reads back as 1 for one cycle and then clears by itself. Step requests are ignored while bit 1 is set.
- R7: Window reads return the addressed word's bytes from least to most significant. The address advances after the fourth read. A write on the same cycle takes precedence over a read.
- R8: Reading select 2 returns address bits 7:0. Reading select 3 returns address bit 8 in bit 0, with zeros in the other bits. Reading select 0 returns the control register.
- R9: After reset the address, byte lane, control register and program counter are all zero.
- R10: A step request raises the program counter by one, wrapping from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (advances the window lane) |
| reg_sel | input | 2 | 0 control, 1 data window, 2 address low, 3 address high |
| wr_byte | input | 8 | Host write data |
| rd_byte | output | 8 | Read data for the selected register (combinational) |
| seq_step | input | 1 | Sequencer request to advance the program counter |
| pc | output | 9 | Sequencer program counter |
| cfg | output | 8 | Current control register value |

## Verification
The bench targets the lane counter, which gives the most room for error. It checks that the address moves only on the fourth byte, since a design that advanced on every byte would scatter one word over four addresses. It checks that an address write midway through a word restarts at lane 0; a design that kept the lane would commit a word built from stale bytes. It writes at address 511 to expose a missing wrap. It writes with load enable clear to catch a store that is corrupted anyway. It also checks that the reset bit clears itself and holds off step requests for exactly one cycle, and that reads walk the bytes in the same order as writes.

// File: rtl/ucode_loader.sv
module ucode_loader #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic              seq_step,
  output logic [ADDR_W-1:0] pc,
  output logic [7:0]        cfg
);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_WIN = 2'd1, SEL_LO = 2'd2, SEL_HI = 2'd3;

  logic [7:0]               ctrl_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [LANE_W-1:0]        lane_q;
  logic [WORD_W-BYTE_W-1:0] stage_q;
  logic [ADDR_W-1:0]        pc_q;
  logic [WORD_W-1:0]        store [DEPTH];
  logic [WORD_W-1:0]        word_rd;

  wire ctrl_wr  = reg_wr && reg_sel == SEL_CTRL;
  wire addr_wr  = reg_wr && (reg_sel == SEL_LO || reg_sel == SEL_HI);
  wire win_wr   = reg_wr && reg_sel == SEL_WIN && ctrl_q[0];
  wire win_rd   = reg_rd && !reg_wr && reg_sel == SEL_WIN;
  wire win_move = win_wr || win_rd;
  wire commit   = win_wr && lane_q == LAST;

  assign word_rd = store[addr_q];
  assign pc      = pc_q;
  assign cfg     = ctrl_q;

  always_comb begin
    case (reg_sel)
      SEL_CTRL: rd_byte = ctrl_q;
      SEL_WIN:  rd_byte = word_rd[lane_q*BYTE_W +: BYTE_W];
      SEL_LO:   rd_byte = addr_q[BYTE_W-1:0];
      default:  rd_byte = BYTE_W'(addr_q >> BYTE_W);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pc_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_byte;
      else         ctrl_q[1] <= 1'b0;
      if (ctrl_wr && wr_byte[1]) pc_q <= '0;
      else if (!ctrl_q[1] && seq_step) pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lane_q  <= '0;
      stage_q <= '0;
    end else if (addr_wr) begin
      lane_q <= '0;
      if (reg_sel == SEL_LO) addr_q <= {addr_q[ADDR_W-1:BYTE_W], wr_byte};
      else                   addr_q <= {wr_byte[HI_W-1:0], addr_q[BYTE_W-1:0]};
    end else if (win_move) begin
      lane_q <= lane_q + 1'b1;
      if (lane_q == LAST) addr_q <= addr_q + 1'b1;
      if (win_wr && lane_q != LAST) stage_q[lane_q*BYTE_W +: BYTE_W] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) store[addr_q] <= {wr_byte, stage_q};
  end

  a_r2_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> addr_q == $past(addr_q) + 1'b1 && lane_q == '0);
  a_r2_no_early_step: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && lane_q != LAST) |=> $stable(addr_q));
  a_r4_locked_window: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_WIN && !ctrl_q[0]) |=> $stable(addr_q) && $stable(lane_q));
  a_r5_lane_restart: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> lane_q == '0);
  a_r6_pc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_byte[1]) |=> pc_q == '0 && ctrl_q[1]);
  a_r6_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !ctrl_wr) |=> !ctrl_q[1] && $stable(pc_q));
endmodule

// File: tb/test_ucode_loader.sv
module test_ucode_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, seq_step = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_byte = 8'd0;
  logic [7:0] rd_byte, cfg;
  logic [8:0] pc;

  ucode_loader i_ucode_loader (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .wr_byte(wr_byte), .rd_byte(rd_byte), .seq_step(seq_step),
    .pc(pc), .cfg(cfg));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mm [512];
  bit          mv [512];
  logic [31:0] m_stage;
  int m_addr = 0, m_lane = 0, m_pc = 0;
  logic [7:0] m_ctrl = 8'd0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int expect_rd(input logic [1:0] s, output bit known);
    known = 1'b1;
    case (s)
      2'd0: return int'(m_ctrl);
      2'd1: begin known = mv[m_addr]; return int'(mm[m_addr][m_lane*8 +: 8]); end
      2'd2: return m_addr % 256;
      default: return m_addr / 256;
    endcase
  endfunction

  task automatic op(input string tag, input bit we, input bit re, input logic [1:0] s,
                    input logic [7:0] d, input bit st);
    bit known;
    int e;
    logic [7:0] oc;
    @(negedge clk);
    reg_wr = we; reg_rd = re; reg_sel = s; wr_byte = d; seq_step = st;
    #1;
    e = expect_rd(s, known);
    if (known) chk(tag, "rd_byte", int'(rd_byte), e);
    oc = m_ctrl;
    if (we && s == 2'd0 && d[1]) m_pc = 0;
    else if (!oc[1] && st) m_pc = (m_pc + 1) % 512;
    if (we && s == 2'd0) m_ctrl = d; else m_ctrl[1] = 1'b0;
    if (we && s == 2'd2) begin m_addr = (m_addr / 256) * 256 + d; m_lane = 0; end
    else if (we && s == 2'd3) begin m_addr = (m_addr % 256) + 256 * d[0]; m_lane = 0; end
    else if ((we && s == 2'd1 && oc[0]) || (re && !we && s == 2'd1)) begin
      if (we) begin
        m_stage[m_lane*8 +: 8] = d;
        if (m_lane == 3) begin mm[m_addr] = m_stage; mv[m_addr] = 1'b1; end
      end
      if (m_lane == 3) begin m_lane = 0; m_addr = (m_addr + 1) % 512; end
      else m_lane++;
    end
    @(posedge clk); #1;
    chk(tag, "pc", int'(pc), m_pc);
    chk(tag, "cfg", int'(cfg), int'(m_ctrl));
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input logic [7:0] d);
    op(tag, 1'b1, 1'b0, s, d, 1'b0);
  endtask
  task automatic rd(input string tag, input logic [1:0] s);
    op(tag, 1'b0, 1'b1, s, 8'h00, 1'b0);
  endtask
  task automatic set_addr(input string tag, input int a);
    wr(tag, 2'd2, 8'(a % 256));
    wr(tag, 2'd3, 8'(a / 256));
  endtask
  task automatic put_word(input string tag, input logic [31:0] w);
    for (int k = 0; k < 4; k++) wr(tag, 2'd1, w[k*8 +: 8]);
  endtask
  task automatic get_word(input string tag);
    for (int k = 0; k < 4; k++) rd(tag, 2'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R9", "pc", int'(pc), 0);
    chk("R9", "cfg", int'(cfg), 0);
    rd("R9", 2'd2);
    rd("R9", 2'd3);
    // R4: locked window leaves address and lane alone
    wr("R4", 2'd1, 8'hAA);
    wr("R4", 2'd1, 8'hBB);
    rd("R4", 2'd2);
    wr("R4", 2'd0, 8'h01);
    // R1 R2: words at 0 and 1, address checked mid-word
    for (int k = 0; k < 3; k++) wr("R2", 2'd1, 8'(8'h10 + k));
    rd("R2", 2'd2);
    wr("R1", 2'd1, 8'h13);
    rd("R2", 2'd2);
    put_word("R1", 32'hDEADBEEF);
    set_addr("R7", 0);
    get_word("R7");
    get_word("R7");
    rd("R7", 2'd2);
    // R5: partial word abandoned by address write
    set_addr("R5", 5);
    wr("R5", 2'd1, 8'h77);
    wr("R5", 2'd1, 8'h66);
    set_addr("R5", 7);
    put_word("R5", 32'h0A0B0C0D);
    set_addr("R5", 7);
    get_word("R5");
    rd("R8", 2'd2);
    // R3: wrap from 511 to 0
    set_addr("R3", 511);
    rd("R8", 2'd3);
    put_word("R3", 32'hCAFEF00D);
    rd("R3", 2'd2);
    rd("R3", 2'd3);
    set_addr("R3", 511);
    get_word("R3");
    rd("R3", 2'd2);
    // R7: a write outranks a read on the same cycle
    set_addr("R7", 20);
    op("R7", 1'b1, 1'b1, 2'd1, 8'h55, 1'b0);
    for (int k = 1; k < 4; k++) wr("R7", 2'd1, 8'(k));
    set_addr("R7", 20);
    get_word("R7");
    // R4: locked again, stored word unchanged
    wr("R4", 2'd0, 8'h00);
    set_addr("R4", 20);
    put_word("R4", 32'h99999999);
    rd("R4", 2'd2);
    get_word("R4");
    // R10: stepping and wrap
    for (int k = 0; k < 515; k++) op("R10", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    // R6: reset bit clears pc, holds one cycle, self-clears
    op("R6", 1'b1, 1'b0, 2'd0, 8'hF2, 1'b1);
    op("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    op("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    op("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    rd("R8", 2'd0);
    // R1: many words, varied patterns
    wr("R1", 2'd0, 8'h01);
    set_addr("R1", 250);
    for (int w = 0; w < 12; w++) put_word("R1", 32'h01234567 * (w + 3) ^ {w[7:0], 24'h5A5A5A});
    set_addr("R1", 250);
    for (int w = 0; w < 12; w++) get_word("R1");
    rd("R8", 2'd3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule